// File: doc/BRIEF.md
# Serial Ones Tally Unit

This unit finds how many bits are set in a data word by examining the word one bit per step instead of with a wide adder tree. When the unit is idle and `start` is high, it captures the word in a shift register and presets a tally register to all ones. The unit then alternates between shifting the word right and bumping the tally. The tally is bumped once on entry, which wraps it to zero, and once more for every 1 that leaves the low end of the word.

The run ends when the tally step finds that the shift register holds only zeros. The unit then returns to idle, raises `idle`, and holds the result on `count` until the next accepted start. The controller has four states encoded in two bits, a per-state multiplexer for each next-state bit, and a decoder that produces the datapath strobes.

Top module: `ones_tally`

## Requirements
- R1: After reset is released, `idle` is 1 and `count` is 0.
- R2: When `idle` is 1 and `start` is 1 at a rising edge, the unit captures `dataIn` at that edge and `idle` reads 0 in the following cycle.
- R3: While `idle` is 0, `start` and `dataIn` have no effect: the final `count` reflects only the word captured at the accepted start.
- R4: When `idle` rises again, `count` equals the number of 1 bits in the captured word. This includes the all-ones word, which gives WIDTH.
- R5: An all-zero word gives `count` 0, with `idle` low for exactly one cycle.
- R6: For a nonzero word with p set bits whose highest set bit is at index h (0 = LSB), `idle` stays low for exactly p + 1 + 2*(h+1) cycles.
- R7: While `idle` is 1 and no start is accepted, `count` does not change, whatever `dataIn` does.
- R8: While `idle` is 1 and `start` is 0, `idle` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a tally; sampled only while idle |
| dataIn | input | WIDTH | Word whose set bits are tallied |
| count | output | WIDTH | Tally result, valid while idle |
| idle | output | 1 | High when the unit waits for a start |

## Verification
A start driven on one falling edge is accepted at the next rising edge, so `idle` is already low at the falling edge that follows. The bench counts the falling edges at which `idle` reads low. That number must match the R6 formula, or exactly one for a zero word. `count` is compared with a bench popcount at the first falling edge after `idle` returns high. Stability of the held result is then sampled over several later falling edges while `dataIn` is changed.

// File: rtl/tally_pkg.sv
package tally_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_BUMP  = 2'b01,
    ST_SHIFT = 2'b10,
    ST_TEST  = 2'b11
  } tallyState_e;

  typedef struct packed {
    logic loadWord;
    logic bumpTally;
    logic shiftWord;
  } tallyStrobe_t;
endpackage

// File: rtl/tally_ctrl.sv
module tally_ctrl
  import tally_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         wordZero,
  input  logic         lastBit,
  output tallyStrobe_t strb,
  output logic         idle
);
  localparam int NUM_ST = 4;

  logic [1:0]        stateQ;
  logic [1:0]        stateD;
  logic [NUM_ST-1:0] dec;
  logic [NUM_ST-1:0] muxHi;
  logic [NUM_ST-1:0] muxLo;

  // Multiplexer data inputs, one pair per present state
  assign muxHi[ST_IDLE]  = 1'b0;
  assign muxLo[ST_IDLE]  = start;
  assign muxHi[ST_BUMP]  = ~wordZero;
  assign muxLo[ST_BUMP]  = 1'b0;
  assign muxHi[ST_SHIFT] = 1'b1;
  assign muxLo[ST_SHIFT] = 1'b1;
  assign muxHi[ST_TEST]  = ~lastBit;
  assign muxLo[ST_TEST]  = lastBit;

  assign stateD = {muxHi[stateQ], muxLo[stateQ]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  // State decoder
  for (genvar i = 0; i < NUM_ST; i++) begin : g_dec
    assign dec[i] = (stateQ == i[1:0]);
  end

  assign strb.loadWord  = dec[ST_IDLE] & start;
  assign strb.bumpTally = dec[ST_BUMP];
  assign strb.shiftWord = dec[ST_SHIFT];
  assign idle           = dec[ST_IDLE];

  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (idle && start) |=> (stateQ == ST_BUMP)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (idle && !start) |=> idle); // R8
  AST_BUMP_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.bumpTally && wordZero) |=> idle); // R4
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadWord, strb.bumpTally, strb.shiftWord})); // R3
endmodule

// File: rtl/tally_data.sv
module tally_data
  import tally_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  tallyStrobe_t       strb,
  input  logic [WIDTH-1:0]   dataIn,
  output logic [WIDTH-1:0]   count,
  output logic               wordZero,
  output logic               lastBit
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] wordQ;
  logic [WIDTH-1:0] tallyQ;
  logic             bitQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordQ <= '0;
    end else if (strb.loadWord) begin
      wordQ <= dataIn;
    end else if (strb.shiftWord) begin
      wordQ <= {1'b0, wordQ[WIDTH-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               bitQ <= 1'b0;
    else if (strb.shiftWord) bitQ <= wordQ[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tallyQ <= '0;
    end else if (strb.loadWord) begin
      tallyQ <= ALL_ONES;
    end else if (strb.bumpTally) begin
      tallyQ <= tallyQ + ONE;
    end
  end

  assign wordZero = (wordQ == '0);
  assign lastBit  = bitQ;
  assign count    = tallyQ;

  AST_PRESET_ONES: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadWord |=> (tallyQ == ALL_ONES)); // R2
  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftWord |=> (wordQ[WIDTH-1] == 1'b0)); // R4
  AST_TALLY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadWord && !strb.bumpTally) |=> $stable(tallyQ)); // R7
  AST_BIT_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftWord |=> (bitQ == $past(wordQ[0]))); // R4
endmodule

// File: rtl/ones_tally.sv
module ones_tally
  import tally_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] count,
  output logic             idle
);
  tallyStrobe_t strb;
  logic         wordZero;
  logic         lastBit;

  tally_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .wordZero (wordZero),
    .lastBit  (lastBit),
    .strb     (strb),
    .idle     (idle)
  );

  tally_data #(.WIDTH(WIDTH)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .dataIn   (dataIn),
    .count    (count),
    .wordZero (wordZero),
    .lastBit  (lastBit)
  );
endmodule

// File: tb/ones_tally_bench.sv
`timescale 1ns/1ps
module ones_tally_bench;
  localparam int WIDTH = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [WIDTH-1:0] dataIn = '0;
  logic [WIDTH-1:0] count;
  logic             idle;

  int nChecks = 0;
  int nFails = 0;

  always #4 clk = ~clk;

  ones_tally #(.WIDTH(WIDTH)) u_ones_tally (
    .clk(clk), .rstN(rstN), .start(start),
    .dataIn(dataIn), .count(count), .idle(idle)
  );

  function automatic int popCount(input logic [WIDTH-1:0] w);
    int n = 0;
    for (int i = 0; i < WIDTH; i++) n += int'(w[i]);
    return n;
  endfunction

  function automatic int busyCycles(input logic [WIDTH-1:0] w);
    int h = -1;
    for (int i = 0; i < WIDTH; i++) if (w[i]) h = i;
    if (h < 0) return 1;
    return popCount(w) + 1 + 2 * (h + 1);
  endfunction

  task automatic check(input string req, input int actual, input int expected);
    nChecks++;
    if (actual != expected) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic finish();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  // Runs one tally; optionally pokes start with another word mid-run (R3)
  task automatic runOne(input logic [WIDTH-1:0] w, input bit poke, input string req);
    int busy = 0;
    @(negedge clk);
    start = 1'b1;
    dataIn = w;
    @(negedge clk);
    start = 1'b0;
    dataIn = ~w;
    check("R2 idle low after start", int'(idle), 0);
    while (!idle && busy < 1000) begin
      busy++;
      if (poke && busy == 2) begin
        start = 1'b1;
        dataIn = ~w;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check({req, " R4 count"}, int'(count), popCount(w));
    if (w == '0) check("R5 zero-word busy", busy, 1);
    else         check("R6 busy cycles", busy, busyCycles(w));
  endtask

  initial begin
    #(8 * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    logic [WIDTH-1:0] held;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", int'(idle), 1);
    check("R1 count after reset", int'(count), 0);

    // R8: idle persists without start
    repeat (4) begin
      dataIn = WIDTH'($urandom);
      @(negedge clk);
      check("R8 stays idle", int'(idle), 1);
    end

    runOne('0, 1'b0, "R5");
    runOne('1, 1'b0, "all-ones");
    runOne(8'h80, 1'b0, "msb");
    runOne(8'h01, 1'b0, "lsb");
    runOne(8'h55, 1'b1, "R3 poke");
    runOne(8'h10, 1'b1, "R3 poke");

    // R7: result held while idle and dataIn wanders
    held = count;
    repeat (5) begin
      dataIn = WIDTH'($urandom);
      @(negedge clk);
      check("R7 count held", int'(count), int'(held));
    end

    for (int k = 0; k < 40; k++) begin
      runOne(WIDTH'($urandom), k[0], "random");
    end

    finish();
  end
endmodule